// File: doc/BRIEF.md
# Page-Boundary Write Splitter

This block takes one byte-granular flash write request, given as a start byte address and a byte count, and cuts it into program bursts. No burst ever runs past the end of a flash page. A request that starts in the middle of a page first gets a short burst that fills up to the next page edge. After that come whole-page bursts. A final short burst, if one is needed, starts at a page-aligned address. A request that fits inside one page produces a single burst that carries the full count.

Each burst goes to a downstream command engine as a flash address, a length and a buffer offset. The buffer offset is the number of request bytes already handed out, so the engine can take the matching bytes from the caller's data stream. The page size is set as a shift parameter; the default of 8 gives 256-byte pages.

Requests enter on a valid/ready port. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and the request fields must be held until then. Bursts leave on a valid/ready port. While `burst_valid` is high and `burst_ready` is low, the burst fields stay frozen, and the engine can stall for as long as it needs. After a burst is taken, the engine reports that it has finished with a one-cycle `burst_done` pulse. Only one burst is outstanding at any time. `req_done` pulses once per request.

Top module: `page_write_splitter`

## Requirements
- R1: After reset, `burst_valid` and `req_done` are low and `req_ready` is high.
- R2: For every offered burst, the page offset of `burst_addr` plus `burst_len` is no more than the page size, so no burst crosses a page edge.
- R3: `burst_len` is PAGE_SHIFT+1 bits wide and holds the byte count directly, from 1 up to the page size. The full page size (256 at default) is a legal value.
- R4: When the request's bytes all lie in the page of the start address, exactly one burst is issued. It carries the start address and the full count.
- R5: When the request spans pages, the first burst length equals the page size minus the start address modulo the page size.
- R6: Every burst between the first and the last is a full page at a page-aligned address.
- R7: The bursts of a request have contiguous addresses. Their lengths add up to the count. A trailing burst shorter than a page starts page-aligned.
- R8: `burst_offset` is 0 for the first burst of a request and equals the sum of the earlier burst lengths of that request for the ones after it.
- R9: While `burst_valid` is high and `burst_ready` is low, `burst_valid`, `burst_addr`, `burst_len` and `burst_offset` hold their values into the next cycle.
- R10: After a burst is accepted, `burst_valid` stays low until `burst_done` has been seen.
- R11: A request with count 0 issues no burst, and `req_done` pulses in the cycle after it is accepted.
- R12: For a non-empty request, `req_done` pulses in the same cycle as the `burst_done` of its final burst. `req_ready` is high in that cycle, so a following request can be accepted in it.
- R13: From the acceptance of a non-empty request until its final `burst_done`, `req_ready` is low except in that final cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A write request is offered |
| req_ready | output | 1 | The splitter can take a request this cycle |
| req_addr | input | ADDR_W | Start byte address of the request |
| req_count | input | CNT_W | Byte count of the request (0 allowed) |
| req_done | output | 1 | One-cycle pulse when the request is complete |
| burst_valid | output | 1 | A program burst is offered |
| burst_ready | input | 1 | The engine accepts the offered burst |
| burst_addr | output | ADDR_W | Flash byte address of the burst |
| burst_len | output | PAGE_SHIFT+1 | Burst byte length, 1 to page size |
| burst_offset | output | CNT_W | Byte offset of the burst within the caller's buffer |
| burst_done | input | 1 | The engine has finished the accepted burst |

## Verification
Two things can happen in the same cycle. The final `burst_done` of one request can complete it, and the splitter can accept the next request. The bench sets up this chaining by raising `req_valid` with new fields in the exact cycle it pulses the last `burst_done`, including the case where the chained request has a count of zero. In that cycle it checks that `req_done` and `req_ready` are both high. It then checks that the chained request's first burst, or its zero-count completion, follows one cycle later with the offset reset to 0.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } pws_state_e;
endpackage

// File: rtl/pws_chunk_calc.sv
module pws_chunk_calc #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 8
) (
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic [CNT_W-1:0]    bytes_left,
  output logic [PAGE_SHIFT:0] chunk_len
);
  localparam int LEN_W      = PAGE_SHIFT + 1;
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
  localparam int CMP_W      = (CNT_W > LEN_W) ? CNT_W : LEN_W;

  logic [LEN_W-1:0] room;
  logic [CMP_W-1:0] left_w;
  logic [CMP_W-1:0] room_w;

  // bytes between the cursor and the next page edge
  always_comb begin
    room   = LEN_W'(PAGE_BYTES) - {1'b0, cur_addr[PAGE_SHIFT-1:0]};
    left_w = CMP_W'(bytes_left);
    room_w = CMP_W'(room);
    if (left_w < room_w) chunk_len = left_w[LEN_W-1:0];
    else                 chunk_len = room;
  end
endmodule

// File: rtl/pws_cursor.sv
module pws_cursor #(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic [CNT_W-1:0]    load_count,
  input  logic                advance,
  input  logic [PAGE_SHIFT:0] step,
  output logic [ADDR_W-1:0]   cur_addr,
  output logic [CNT_W-1:0]    bytes_left,
  output logic [CNT_W-1:0]    buf_offset
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      bytes_left <= '0;
      buf_offset <= '0;
    end else if (load) begin
      cur_addr   <= load_addr;
      bytes_left <= load_count;
      buf_offset <= '0;
    end else if (advance) begin
      cur_addr   <= cur_addr + ADDR_W'(step);
      bytes_left <= bytes_left - CNT_W'(step);
      buf_offset <= buf_offset + CNT_W'(step);
    end
  end
endmodule

// File: rtl/page_write_splitter.sv
module page_write_splitter
  import pws_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CNT_W-1:0]    req_count,
  output logic                req_done,
  output logic                burst_valid,
  input  logic                burst_ready,
  output logic [ADDR_W-1:0]   burst_addr,
  output logic [PAGE_SHIFT:0] burst_len,
  output logic [CNT_W-1:0]    burst_offset,
  input  logic                burst_done
);
  localparam int LEN_W      = PAGE_SHIFT + 1;
  localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

  pws_state_e state_q, state_d;
  logic       zero_done_q;
  logic       req_fire, final_done, issue_fire;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  bytes_left, buf_offset;
  logic [LEN_W-1:0]  chunk_len;

  assign final_done = (state_q == ST_WAIT) && burst_done && (bytes_left == '0);
  assign req_ready  = (state_q == ST_IDLE) || final_done;
  assign req_fire   = req_valid && req_ready;
  assign issue_fire = (state_q == ST_ISSUE) && burst_ready;
  assign req_done   = zero_done_q || final_done;

  assign burst_valid  = (state_q == ST_ISSUE);
  assign burst_addr   = cur_addr;
  assign burst_len    = chunk_len;
  assign burst_offset = buf_offset;

  pws_chunk_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT)) u_calc (
    .cur_addr   (cur_addr),
    .bytes_left (bytes_left),
    .chunk_len  (chunk_len)
  );

  pws_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (req_fire),
    .load_addr  (req_addr),
    .load_count (req_count),
    .advance    (issue_fire),
    .step       (chunk_len),
    .cur_addr   (cur_addr),
    .bytes_left (bytes_left),
    .buf_offset (buf_offset)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_fire) state_d = (req_count == '0) ? ST_IDLE : ST_ISSUE;
      ST_ISSUE: if (burst_ready) state_d = ST_WAIT;
      ST_WAIT: begin
        if (burst_done) begin
          if (bytes_left != '0)  state_d = ST_ISSUE;
          else if (req_fire)     state_d = (req_count == '0) ? ST_IDLE : ST_ISSUE;
          else                   state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      zero_done_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      zero_done_q <= req_fire && (req_count == '0);
    end
  end

  // page edge is never crossed
  assert_page_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> ({1'b0, burst_addr[PAGE_SHIFT-1:0]} + LEN_W'(burst_len)) <= (LEN_W+1)'(PAGE_BYTES));

  assert_len_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_len != '0) && (burst_len <= LEN_W'(PAGE_BYTES)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_addr) &&
                                        $stable(burst_len) && $stable(burst_offset)));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && burst_ready) |=> !burst_valid);

  assert_zero_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_count == '0)) |=> (req_done && !burst_valid));

  assert_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> !req_ready);
endmodule

// File: tb/test_page_write_splitter.sv
`timescale 1ns/1ps
module test_page_write_splitter;
  localparam int ADDR_W     = 24;
  localparam int CNT_W      = 16;
  localparam int PAGE_SHIFT = 8;
  localparam int PAGE       = 1 << PAGE_SHIFT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic req_done;
  logic burst_valid;
  logic burst_ready = 1'b0;
  logic [ADDR_W-1:0] burst_addr;
  logic [PAGE_SHIFT:0] burst_len;
  logic [CNT_W-1:0] burst_offset;
  logic burst_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  page_write_splitter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT)) i_page_write_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_count(req_count), .req_done(req_done),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_len(burst_len), .burst_offset(burst_offset), .burst_done(burst_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_chunk(input longint a, input longint left);
    longint room = PAGE - (a % PAGE);
    return (left < room) ? int'(left) : int'(room);
  endfunction

  // Offers a request at a negedge; returns after the accepting edge (+1).
  task automatic send_req(input logic [ADDR_W-1:0] a, input int c);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_count = CNT_W'(c);
    #1;
    chk(req_ready, "R1", "req_ready when idle", req_ready, 1);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Serves the bursts of an accepted request; optionally chains the next one.
  task automatic serve(input logic [ADDR_W-1:0] a, input int c, input bit chain,
                       input logic [ADDR_W-1:0] na, input int nc);
    longint ea = a;
    longint left = c;
    longint off = 0;
    bit first = 1;
    if (c == 0) begin
      @(negedge clk);
      chk(req_done === 1'b1, "R11", "req_done after zero count", req_done, 1);
      chk(burst_valid === 1'b0, "R11", "no burst for zero count", burst_valid, 0);
      @(negedge clk);
      chk(req_done === 1'b0, "R11", "single done pulse", req_done, 0);
      return;
    end
    while (left > 0) begin
      int el;
      int stall;
      int gap;
      logic [ADDR_W-1:0] sa;
      logic [PAGE_SHIFT:0] sl;
      logic [CNT_W-1:0] so;
      @(negedge clk);
      el = exp_chunk(ea, left);
      chk(burst_valid === 1'b1, "R10", "burst offered", burst_valid, 1);
      chk(burst_addr == ADDR_W'(ea), "R7", "burst address", burst_addr, ea % (1 << ADDR_W));
      chk(burst_len == (PAGE_SHIFT+1)'(el), "R3", "burst length", burst_len, el);
      chk(burst_offset == CNT_W'(off), "R8", "buffer offset", burst_offset, off);
      chk((burst_addr % PAGE) + burst_len <= PAGE, "R2", "page bound",
          (burst_addr % PAGE) + burst_len, PAGE);
      if (first && ((a % PAGE) + c <= PAGE))
        chk(burst_len == c, "R4", "single burst length", burst_len, c);
      else if (first)
        chk(burst_len == PAGE - (a % PAGE), "R5", "leading length", burst_len, PAGE - (a % PAGE));
      else if (left > PAGE)
        chk(burst_len == PAGE && burst_addr % PAGE == 0, "R6", "middle full page", burst_len, PAGE);
      else
        chk(burst_addr % PAGE == 0, "R7", "tail aligned", burst_addr % PAGE, 0);
      chk(req_ready === 1'b0, "R13", "busy while offering", req_ready, 0);
      sa = burst_addr; sl = burst_len; so = burst_offset;
      stall = $urandom % 3;
      repeat (stall) begin
        @(negedge clk);
        chk(burst_valid && burst_addr == sa && burst_len == sl && burst_offset == so,
            "R9", "held under stall", burst_len, sl);
      end
      burst_ready = 1'b1;
      @(posedge clk); #1;
      burst_ready = 1'b0;
      gap = $urandom % 3;
      repeat (gap + 1) begin
        @(negedge clk);
        chk(burst_valid === 1'b0, "R10", "no burst before done", burst_valid, 0);
        chk(req_ready === 1'b0, "R13", "busy while waiting", req_ready, 0);
        chk(req_done === 1'b0, "R12", "no early done", req_done, 0);
      end
      left -= el;
      burst_done = 1'b1;
      if (left == 0 && chain) begin
        req_valid = 1'b1; req_addr = na; req_count = CNT_W'(nc);
      end
      #1;
      if (left == 0) begin
        chk(req_done === 1'b1, "R12", "done with final burst", req_done, 1);
        chk(req_ready === 1'b1, "R12", "ready with final burst", req_ready, 1);
      end else begin
        chk(req_done === 1'b0, "R12", "no done mid request", req_done, 0);
      end
      @(posedge clk); #1;
      burst_done = 1'b0;
      req_valid = 1'b0;
      ea = (ea + el) % (1 << ADDR_W);
      off += el;
      first = 0;
    end
  endtask

  task automatic one_req(input logic [ADDR_W-1:0] a, input int c);
    send_req(a, c);
    serve(a, c, 1'b0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a, na;
    int c, nc;
    bit ch;
    void'($urandom(32'h5EED_0123));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(burst_valid === 1'b0, "R1", "reset burst_valid", burst_valid, 0);
    chk(req_done === 1'b0, "R1", "reset req_done", req_done, 0);
    chk(req_ready === 1'b1, "R1", "reset req_ready", req_ready, 1);

    one_req(24'h000010, 16);     // R4 inside one page
    one_req(24'h0000F0, 48);     // R5 two partial pages
    one_req(24'h000100, 256);    // R3 one full aligned page
    one_req(24'h0001FF, 1);      // R4 last byte of a page
    one_req(24'h0000FF, 600);    // R6 R7 lead 1, full pages, tail
    one_req(24'h000080, 0);      // R11 zero count
    one_req(24'h000080, 0);      // R11 back to back
    one_req(24'hFFFFF0, 40);     // R7 address wraps past the top
    // R12 chaining into a zero-count and a non-empty request
    send_req(24'h001234, 300);
    serve(24'h001234, 300, 1'b1, 24'h005000, 0);
    serve(24'h005000, 0, 1'b0, '0, 0);
    send_req(24'h000020, 40);
    serve(24'h000020, 40, 1'b1, 24'h0003F0, 40);
    serve(24'h0003F0, 40, 1'b0, '0, 0);

    a = ADDR_W'($urandom);
    c = $urandom % 1100;
    send_req(a, c);
    for (int i = 0; i < 60; i++) begin
      na = ADDR_W'($urandom);
      if ($urandom % 2) na[PAGE_SHIFT-1:0] = '0;
      nc = ($urandom % 8 == 0) ? 0 : int'($urandom % 1100);
      ch = ($urandom % 2) && (c != 0);
      serve(a, c, ch, na, nc);
      if (!ch) send_req(na, nc);
      a = na; c = nc;
    end
    serve(a, c, 1'b0, '0, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule